// File: doc/BRIEF.md
# Byte-Wide Peripheral Control Register Bank

This block is the register file of a small peripheral. A simple bus with a 4-bit address and 8-bit data reaches it. Each bus cycle carries an address and a read strobe or a write strobe, plus write data. The block decodes the address and applies each bit's own access rule. Depending on the bit, that rule is plain storage, read-only observation of a hardware signal, write-one-to-clear, write-zero-to-set, write-only command delivery, or a reserved bit that reads as zero.

On the hardware side, the block drives an enable bit, an 8-bit mask and a write-only command byte with a one-cycle strobe. It takes a ready flag, an error-set pulse, a per-bit mask clear, and a 32-bit data word. The data word is read over four byte addresses. A read of its lowest byte captures the whole word, so the four reads together return one coherent value.

Top module: `csr_regbank`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the enable bit, the error flag, the mask, the command byte, the command strobe and `r_data` to 0.
- R2: `r_data` is registered. In the cycle after a clock edge with `r_stb` high, it shows the addressed value. In every other cycle it is 0.
- R3: At address 0, bit 0 is a read/write enable that drives `enable_o`. Bits 7:1 read as 0, and writing them changes nothing.
- R4: At address 1, bit 0 reads the live level of `ready_i`. Bit 1 is an error flag. A one-cycle `err_set_i` pulse sets it. A bus write with 1 in bit 1 clears it, and a 0 there leaves it unchanged. Bits 7:2 read as 0.
- R5: If `err_set_i` and a clearing write to address 1 fall in the same cycle, the error flag ends up set.
- R6: At address 2 sits an 8-bit mask that drives `mask_o` and reads back. A write sets every bit whose written value is 0 and leaves bits written 1 unchanged. A high bit of `mask_clr_i` clears the matching mask bit.
- R7: If a bus write sets a mask bit in the same cycle that `mask_clr_i` clears it, the bit ends up set.
- R8: A write to address 3 places `w_data` on `cmd_o` and pulses `cmd_stb_o` high for exactly one cycle. `cmd_o` holds its value afterwards. A read of address 3 returns 0.
- R9: Addresses 4 to 7 hold the 32-bit data word in little-endian order, with address 4 holding bits 7:0. A read of address 4 returns `data_i[7:0]` and captures `data_i`. Reads of 5, 6 and 7 return bits 15:8, 23:16 and 31:24 of that captured word, even if `data_i` has changed since.
- R10: Addresses 8 to 15 read as 0, and writes to them alter no stored field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 4 | Bus byte address |
| r_stb | input | 1 | Read strobe |
| w_stb | input | 1 | Write strobe |
| w_data | input | 8 | Write data |
| r_data | output | 8 | Read data, valid the cycle after `r_stb` |
| ready_i | input | 1 | Hardware ready flag |
| err_set_i | input | 1 | Pulse that sets the error flag |
| mask_clr_i | input | 8 | Per-bit clear of the mask |
| data_i | input | 32 | Wide read-only data word |
| enable_o | output | 1 | Enable bit |
| mask_o | output | 8 | Mask value |
| cmd_o | output | 8 | Last command byte written |
| cmd_stb_o | output | 1 | One-cycle command strobe |

## Verification
A corrupted stored bit shows up as soon as `enable_o` or `mask_o` changes, or on the next read one cycle later. A corrupted error flag is hidden until status is read. A stale or missing snapshot only appears on reads of bytes 5 to 7 after `data_i` has moved, so the bench changes `data_i` between beats. Wrong arbitration between set and clear shows only in the cycle after both events coincide, so those events are driven in the same cycle and the result is read straight afterwards.

// File: rtl/csr_regbank.sv
module csr_regbank #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          r_stb,
  input  logic          w_stb,
  input  logic [DW-1:0] w_data,
  output logic [DW-1:0] r_data,
  input  logic          ready_i,
  input  logic          err_set_i,
  input  logic [DW-1:0] mask_clr_i,
  input  logic [4*DW-1:0] data_i,
  output logic          enable_o,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] cmd_o,
  output logic          cmd_stb_o
);
  localparam int WW = 4 * DW;

  logic          en_q, err_q;
  logic [DW-1:0] mask_q;
  logic [WW-1:DW] snap_q;
  logic [DW-1:0] rd_mux;

  wire wr_ctrl = w_stb && addr == AW'(0);
  wire wr_stat = w_stb && addr == AW'(1);
  wire wr_mask = w_stb && addr == AW'(2);
  wire wr_cmd  = w_stb && addr == AW'(3);

  assign enable_o = en_q;
  assign mask_o   = mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      err_q     <= 1'b0;
      mask_q    <= '0;
      cmd_o     <= '0;
      cmd_stb_o <= 1'b0;
    end else begin
      if (wr_ctrl) en_q <= w_data[0];
      if (err_set_i) err_q <= 1'b1;
      else if (wr_stat && w_data[1]) err_q <= 1'b0;
      mask_q    <= (mask_q & ~mask_clr_i) | ({DW{wr_mask}} & ~w_data);
      cmd_stb_o <= wr_cmd;
      if (wr_cmd) cmd_o <= w_data;
    end
  end

  always_comb begin
    case (addr)
      AW'(0):  rd_mux = {{(DW-1){1'b0}}, en_q};
      AW'(1):  rd_mux = {{(DW-2){1'b0}}, err_q, ready_i};
      AW'(2):  rd_mux = mask_q;
      AW'(4):  rd_mux = data_i[DW-1:0];
      AW'(5):  rd_mux = snap_q[2*DW-1:DW];
      AW'(6):  rd_mux = snap_q[3*DW-1:2*DW];
      AW'(7):  rd_mux = snap_q[4*DW-1:3*DW];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r_data <= '0;
      snap_q <= '0;
    end else begin
      r_data <= r_stb ? rd_mux : '0;
      if (r_stb && addr == AW'(4)) snap_q <= data_i[WW-1:DW];
    end
  end

  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !r_stb |=> r_data == '0);
  assert_ctrl_reserved_R3: assert property (@(posedge clk) disable iff (rst)
    (r_stb && addr == AW'(0)) |=> r_data[DW-1:1] == '0);
  assert_err_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
    err_set_i |=> (r_stb && addr == AW'(1)) |=> r_data[1]);
  assert_mask_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    wr_mask |=> (mask_o & ~$past(w_data)) == ~$past(w_data));
  assert_cmd_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_stb_o |-> $past(w_stb && addr == AW'(3)));
endmodule

// File: tb/csr_regbank_test.sv
module csr_regbank_test;
  logic clk = 0, rst = 1;
  logic [3:0] addr = 0;
  logic r_stb = 0, w_stb = 0, ready_i = 0, err_set_i = 0;
  logic [7:0] w_data = 0, mask_clr_i = 0;
  logic [31:0] data_i = 0;
  logic [7:0] r_data, mask_o, cmd_o;
  logic enable_o, cmd_stb_o;
  int total = 0, bad = 0;
  bit done = 0;

  csr_regbank uut (.clk, .rst, .addr, .r_stb, .w_stb, .w_data, .r_data,
    .ready_i, .err_set_i, .mask_clr_i, .data_i, .enable_o, .mask_o, .cmd_o,
    .cmd_stb_o);

  always #10 clk = ~clk;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    addr = a; w_data = d; w_stb = 1;
    @(negedge clk); w_stb = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] v);
    addr = a; r_stb = 1;
    @(negedge clk); r_stb = 0; v = r_data;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 enable", enable_o, 0); check("R1 mask", mask_o, 0);
    check("R1 cmd", cmd_o, 0); check("R1 stb", cmd_stb_o, 0);
    check("R1 rdata", r_data, 0);
    rd(1, v); check("R1 status", v, 0);
  endtask

  task automatic t_ctrl;
    logic [7:0] v;
    wr(0, 8'hFF); check("R3 enable", enable_o, 1);
    rd(0, v); check("R3 read", v, 8'h01);
    @(negedge clk); check("R2 idle zero", r_data, 0);
    wr(0, 8'hFE); check("R3 clear", enable_o, 0);
  endtask

  task automatic t_status;
    logic [7:0] v;
    ready_i = 1; rd(1, v); check("R4 ready", v, 8'h01);
    ready_i = 0;
    err_set_i = 1; @(negedge clk); err_set_i = 0;
    rd(1, v); check("R4 err set", v, 8'h02);
    wr(1, 8'hFD); rd(1, v); check("R4 write0 keeps", v, 8'h02);
    wr(1, 8'h02); rd(1, v); check("R4 w1c", v, 8'h00);
    err_set_i = 1; wr(1, 8'h02); err_set_i = 0;
    rd(1, v); check("R5 set wins", v, 8'h02);
    wr(1, 8'h02);
  endtask

  task automatic t_mask;
    logic [7:0] v;
    wr(2, 8'hF0); check("R6 set low", mask_o, 8'h0F);
    wr(2, 8'hFF); check("R6 ones keep", mask_o, 8'h0F);
    mask_clr_i = 8'h05; @(negedge clk); mask_clr_i = 0;
    rd(2, v); check("R6 hw clear", v, 8'h0A);
    mask_clr_i = 8'h03; wr(2, 8'hFE); mask_clr_i = 0;
    check("R7 set wins", mask_o, 8'h09);
  endtask

  task automatic t_cmd;
    logic [7:0] v;
    addr = 3; w_data = 8'hA5; w_stb = 1;
    @(negedge clk); w_stb = 0;
    check("R8 stb", cmd_stb_o, 1); check("R8 value", cmd_o, 8'hA5);
    @(negedge clk); check("R8 stb one cycle", cmd_stb_o, 0);
    check("R8 hold", cmd_o, 8'hA5);
    rd(3, v); check("R8 read zero", v, 0);
  endtask

  task automatic t_wide;
    logic [7:0] v;
    data_i = 32'h44332211; rd(4, v); check("R9 byte0", v, 8'h11);
    data_i = 32'hAABBCCDD;
    rd(5, v); check("R9 byte1 snap", v, 8'h22);
    rd(6, v); check("R9 byte2 snap", v, 8'h33);
    rd(7, v); check("R9 byte3 snap", v, 8'h44);
    rd(4, v); check("R9 new byte0", v, 8'hDD);
    rd(7, v); check("R9 new byte3", v, 8'hAA);
  endtask

  task automatic t_unmapped;
    logic [7:0] v;
    wr(0, 8'h01);
    wr(8, 8'h00); wr(10, 8'h00); wr(9, 8'hFF);
    check("R10 enable kept", enable_o, 1);
    check("R10 mask kept", mask_o, 8'h09);
    check("R10 no cmd", cmd_o, 8'hA5);
    rd(1, v); check("R10 status kept", v, 0);
    rd(12, v); check("R10 read zero", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset(); t_ctrl(); t_status(); t_mask(); t_cmd(); t_wide(); t_unmapped();
    rst = 1; @(negedge clk); rst = 0;
    check("R1 enable after reset", enable_o, 0);
    check("R1 mask after reset", mask_o, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule